// File: doc/BRIEF.md
# Radio Front-End Serial Control Sequencer

This block lets a host program a radio front end over one shared serial clock and data pair. Two targets hang on that pair. One is a transceiver configuration port that listens only while its active-low select is low. The other is an external 8-bit shift-and-hold output register that takes in what has been shifted when its separate latch line rises. The host raises a one-cycle request that says which target is meant and carries the word. The block turns that request into a timed bus sequence and reports `busy` until the sequence has finished.

Before a control-register update goes out, hardware checks two rules. Both amplifier-enable bits may not be set together. Transmit enable and receive enable may not be set together. A request that breaks either rule is dropped with a one-cycle `reject` pulse, and the bus stays quiet. A mirror of the last committed register value is available as status.

The block also holds three antenna-path select outputs, which the host writes, and it brings a PLL lock-detect input into the clock domain through a synchronizer.

Top module: `rf_ctl_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `xcvr_sel_n`=1, `ser_clk`=0, `ser_data`=0, `reg_latch`=0, `busy`=0 and `ctrl_state`=0. A reset in the middle of a transfer abandons the transfer.
- R2: A transceiver write (`req_is_reg`=0) shifts all XW bits of `req_word` MSB first. `ser_data` changes only when `ser_clk` falls, or while `ser_clk` is low, and it is valid at every rising edge of `ser_clk`. `xcvr_sel_n` is low at every one of those rising edges.
- R3: `xcvr_sel_n` falls on the clock edge that accepts the request. It falls one bit period (2*HALF_DIV clocks) before the first rise of `ser_clk` and rises one bit period after the last fall. `busy` stays high for (2*XW+3)*HALF_DIV cycles.
- R4: A control-register update (`req_is_reg`=1) shifts CW=8 bits with bit 0 first and `xcvr_sel_n` held high. After the last bit, `reg_latch` is high for one bit period. `ctrl_state` takes the new value on the edge where `reg_latch` rises. `busy` stays high for 19*HALF_DIV cycles.
- R5: `reg_latch` stays low for the whole time `xcvr_sel_n` is low.
- R6: Register bit map: bit 0 powers the transceiver on, bit 1 enables transmit, bit 2 enables receive, bit 3 turns on the 5 GHz amplifier, bit 4 turns on the 2 GHz amplifier, and bits 5 to 7 are spare outputs. The transmit-ready value 8'h13 is accepted and committed.
- R7: A register request with bits 3 and 4 both set produces `reject`=1 for exactly one cycle, the cycle after it is accepted. It causes no `ser_clk`, select or latch activity, and `ctrl_state` keeps its value.
- R8: A register request with bits 1 and 2 both set is rejected in the same way as in R7.
- R9: A request raised while `busy`=1 is ignored. It causes no reject, no extra bits and no latch.
- R10: `ant_sel` (0 = straight path, 1 = crossed path) loads `ant_din` one cycle after `ant_wr`=1. It holds its value while `ant_wr`=0.
- R11: `lock_ok` follows `lock_raw` after SYNC_STAGES=2 clock edges.
- R12: While `busy`=0, `ser_clk`=0, `xcvr_sel_n`=1 and `reg_latch`=0. A request accepted while idle sets either `busy` or `reject` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_is_reg | input | 1 | 1 = control register update, 0 = transceiver write |
| req_word | input | XW | Word to send; a register update uses bits CW-1:0 |
| busy | output | 1 | A bus sequence is in progress |
| reject | output | 1 | One-cycle pulse when an interlock refuses a request |
| ser_clk | output | 1 | Shared serial clock |
| ser_data | output | 1 | Shared serial data |
| xcvr_sel_n | output | 1 | Active-low transceiver select |
| reg_latch | output | 1 | Commit strobe for the output register |
| ctrl_state | output | CW | Last committed register value |
| ant_wr | input | 1 | Load strobe for the antenna selects |
| ant_din | input | AW | New antenna select value |
| ant_sel | output | AW | Antenna path selects |
| lock_raw | input | 1 | Asynchronous PLL lock detect |
| lock_ok | output | 1 | Synchronized lock status |

## Verification
The bound checker enforces the invariants that hold on every cycle. The bus is quiet while idle. The latch never rises during a select window. Data changes only on the low half of the serial clock. A committed value never holds both amplifiers or both directions on. A reject pulse lasts one cycle and leaves the bus idle. `ctrl_state` changes only when the latch rises. The antenna selects hold between writes. Some properties need a whole transfer before they can be judged: the bit order of each target, the select lead and trail times, the exact length of `busy`, that a request is ignored while busy, and recovery from a reset mid-transfer. The bench scenarios show these by decoding the bus and comparing it with the requested words.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TRAIL,
    ST_LATCH
  } seq_state_t;

  // Control register field positions (decoded by the external register)
  localparam int unsigned FLD_PWR  = 0;
  localparam int unsigned FLD_TX   = 1;
  localparam int unsigned FLD_RX   = 2;
  localparam int unsigned FLD_PA5  = 3;
  localparam int unsigned FLD_PA2  = 4;
  localparam int unsigned GUARD_W  = 5;
endpackage

// File: rtl/rfc_phase_gen.sv
module rfc_phase_gen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == CNT_W'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rfc_guard.sv
module rfc_guard
  import rfc_pkg::*;
(
  input  logic [GUARD_W-1:0] fields,
  output logic               pa_clash,
  output logic               dir_clash
);
  assign pa_clash  = fields[FLD_PA5] & fields[FLD_PA2];
  assign dir_clash = fields[FLD_TX]  & fields[FLD_RX];
endmodule

// File: rtl/rfc_sync.sv
module rfc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/rfc_engine.sv
module rfc_engine
  import rfc_pkg::*;
#(
  parameter int unsigned XW = 18,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          is_reg,
  input  logic [XW-1:0] word,
  input  logic          tick,
  output logic          busy,
  output logic          sclk,
  output logic          sdata,
  output logic          sel_n,
  output logic          latch,
  output logic          commit
);
  localparam int unsigned BCW = $clog2(XW);

  seq_state_t     state;
  logic           half;
  logic           kind_q;
  logic [XW-1:0]  shreg;
  logic [BCW-1:0] bits_left;
  logic [XW-1:0]  rev_word;
  logic [XW-1:0]  load_word;
  logic           last_bit;

  // Register words go out bit 0 first: mirror them into the top of the shifter
  always_comb begin
    rev_word = '0;
    for (int i = 0; i < CW; i++) begin
      rev_word[XW-1-i] = word[i];
    end
  end

  assign load_word = is_reg ? rev_word : word;
  assign last_bit  = (bits_left == '0);
  assign commit    = (state == ST_HIGH) && tick && last_bit && kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      half      <= 1'b0;
      kind_q    <= 1'b0;
      shreg     <= '0;
      bits_left <= '0;
      busy      <= 1'b0;
      sclk      <= 1'b0;
      sdata     <= 1'b0;
      sel_n     <= 1'b1;
      latch     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            kind_q    <= is_reg;
            shreg     <= load_word;
            sdata     <= load_word[XW-1];
            bits_left <= is_reg ? BCW'(CW - 1) : BCW'(XW - 1);
            sel_n     <= is_reg;
            busy      <= 1'b1;
            half      <= 1'b0;
            state     <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            if (half) begin
              half  <= 1'b0;
              sclk  <= 1'b1;
              state <= ST_HIGH;
            end else begin
              half <= 1'b1;
            end
          end
        end
        ST_HIGH: begin
          if (tick) begin
            sclk  <= 1'b0;
            shreg <= shreg << 1;
            if (last_bit) begin
              sdata <= 1'b0;
              half  <= 1'b0;
              if (kind_q) begin
                latch <= 1'b1;
                state <= ST_LATCH;
              end else begin
                state <= ST_TRAIL;
              end
            end else begin
              sdata     <= shreg[XW-2];
              bits_left <= bits_left - 1'b1;
              state     <= ST_LOW;
            end
          end
        end
        ST_LOW: begin
          if (tick) begin
            sclk  <= 1'b1;
            state <= ST_HIGH;
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            if (half) begin
              sel_n <= 1'b1;
              busy  <= 1'b0;
              state <= ST_IDLE;
            end else begin
              half <= 1'b1;
            end
          end
        end
        ST_LATCH: begin
          if (tick) begin
            if (half) begin
              latch <= 1'b0;
              busy  <= 1'b0;
              state <= ST_IDLE;
            end else begin
              half <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rf_ctl_top.sv
module rf_ctl_top
  import rfc_pkg::*;
#(
  parameter int unsigned XW          = 18,
  parameter int unsigned CW          = 8,
  parameter int unsigned AW          = 3,
  parameter int unsigned HALF_DIV    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_is_reg,
  input  logic [XW-1:0] req_word,
  output logic          busy,
  output logic          reject,
  output logic          ser_clk,
  output logic          ser_data,
  output logic          xcvr_sel_n,
  output logic          reg_latch,
  output logic [CW-1:0] ctrl_state,
  input  logic          ant_wr,
  input  logic [AW-1:0] ant_din,
  output logic [AW-1:0] ant_sel,
  input  logic          lock_raw,
  output logic          lock_ok
);
  logic          tick;
  logic          accept;
  logic          pa_clash;
  logic          dir_clash;
  logic          illegal;
  logic          start;
  logic          commit;
  logic [CW-1:0] ctrl_pend;

  rfc_guard u_guard (
    .fields    (req_word[GUARD_W-1:0]),
    .pa_clash  (pa_clash),
    .dir_clash (dir_clash)
  );

  assign accept  = req_valid && !busy;
  assign illegal = req_is_reg && (pa_clash || dir_clash);
  assign start   = accept && !illegal;

  rfc_phase_gen #(.HALF_DIV(HALF_DIV)) u_phase (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .tick (tick)
  );

  rfc_engine #(.XW(XW), .CW(CW)) u_engine (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .is_reg (req_is_reg),
    .word   (req_word),
    .tick   (tick),
    .busy   (busy),
    .sclk   (ser_clk),
    .sdata  (ser_data),
    .sel_n  (xcvr_sel_n),
    .latch  (reg_latch),
    .commit (commit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reject     <= 1'b0;
      ctrl_pend  <= '0;
      ctrl_state <= '0;
      ant_sel    <= '0;
    end else begin
      reject <= accept && illegal;
      if (start && req_is_reg) ctrl_pend  <= req_word[CW-1:0];
      if (commit)              ctrl_state <= ctrl_pend;
      if (ant_wr)              ant_sel    <= ant_din;
    end
  end

  rfc_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (lock_raw),
    .dout (lock_ok)
  );
endmodule

// File: rtl/rf_ctl_checker.sv
module rf_ctl_checker
  import rfc_pkg::*;
#(
  parameter int unsigned CW = 8,
  parameter int unsigned AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          busy,
  input logic          reject,
  input logic          ser_clk,
  input logic          ser_data,
  input logic          xcvr_sel_n,
  input logic          reg_latch,
  input logic [CW-1:0] ctrl_state,
  input logic          ant_wr,
  input logic [AW-1:0] ant_sel
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!ser_clk && xcvr_sel_n && !reg_latch)); // R12
  AST_ACCEPT_RESPONDS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> (busy || reject)); // R12
  AST_LATCH_OUTSIDE_SEL: assert property (@(posedge clk) disable iff (rst)
    !xcvr_sel_n |-> !reg_latch); // R5
  AST_DATA_ON_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(ser_data) |-> !ser_clk); // R2
  AST_REJECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    reject |=> !reject); // R7
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    reject |-> (!busy && $stable(ctrl_state))); // R8
  AST_NO_PA_PAIR: assert property (@(posedge clk) disable iff (rst)
    !(ctrl_state[FLD_PA5] && ctrl_state[FLD_PA2])); // R7
  AST_NO_DIR_PAIR: assert property (@(posedge clk) disable iff (rst)
    !(ctrl_state[FLD_TX] && ctrl_state[FLD_RX])); // R8
  AST_STATE_ON_LATCH: assert property (@(posedge clk) disable iff (rst)
    !$stable(ctrl_state) |-> $rose(reg_latch)); // R4
  AST_ANT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(ant_wr) |-> $stable(ant_sel)); // R10
endmodule

bind rf_ctl_top rf_ctl_checker #(.CW(CW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .busy       (busy),
  .reject     (reject),
  .ser_clk    (ser_clk),
  .ser_data   (ser_data),
  .xcvr_sel_n (xcvr_sel_n),
  .reg_latch  (reg_latch),
  .ctrl_state (ctrl_state),
  .ant_wr     (ant_wr),
  .ant_sel    (ant_sel)
);

// File: tb/rf_ctl_top_tb.sv
module rf_ctl_top_tb;
  localparam int XW = 18;
  localparam int CW = 8;
  localparam int AW = 3;
  localparam int H  = 2;
  localparam int NV = 9;
  localparam int XCVR_BUSY = (2 * XW + 3) * H;
  localparam int REG_BUSY  = 19 * H;

  // {is_reg, expect_reject, word}
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 1'b0, 18'h2A5C3},
    {1'b0, 1'b0, 18'h00001},
    {1'b1, 1'b0, 18'h00013},
    {1'b1, 1'b1, 18'h00018},
    {1'b1, 1'b1, 18'h00006},
    {1'b1, 1'b0, 18'h000E5},
    {1'b1, 1'b1, 18'h0001E},
    {1'b1, 1'b0, 18'h00009},
    {1'b0, 1'b0, 18'h3FFFF}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_is_reg = 1'b0;
  logic [XW-1:0] req_word = '0;
  logic          busy, reject, ser_clk, ser_data, xcvr_sel_n, reg_latch, lock_ok;
  logic [CW-1:0] ctrl_state;
  logic          ant_wr = 1'b0;
  logic [AW-1:0] ant_din = '0;
  logic [AW-1:0] ant_sel;
  logic          lock_raw = 1'b0;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  rf_ctl_top #(.XW(XW), .CW(CW), .AW(AW), .HALF_DIV(H), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_reg(req_is_reg),
    .req_word(req_word), .busy(busy), .reject(reject), .ser_clk(ser_clk),
    .ser_data(ser_data), .xcvr_sel_n(xcvr_sel_n), .reg_latch(reg_latch),
    .ctrl_state(ctrl_state), .ant_wr(ant_wr), .ant_din(ant_din),
    .ant_sel(ant_sel), .lock_raw(lock_raw), .lock_ok(lock_ok)
  );

  // Bus monitor
  int          cyc = 0;
  logic [31:0] mon_shift = '0;
  int          mon_cnt = 0;
  int          sel_low_rises = 0;
  int          latch_cnt = 0;
  int          latch_in_sel = 0;
  int          t_sel_fall = 0, t_first_rise = 0, t_last_fall = 0, t_sel_rise = 0;
  bit          want_first = 0;

  always @(negedge clk) cyc++;
  always @(negedge clk) if (!xcvr_sel_n && reg_latch) latch_in_sel++;
  always @(posedge ser_clk) begin
    mon_shift = {mon_shift[30:0], ser_data};
    mon_cnt++;
    if (!xcvr_sel_n) sel_low_rises++;
    if (want_first) begin
      t_first_rise = cyc;
      want_first = 0;
    end
  end
  always @(negedge ser_clk) t_last_fall = cyc;
  always @(negedge xcvr_sel_n) begin
    t_sel_fall = cyc;
    want_first = 1;
  end
  always @(posedge xcvr_sel_n) t_sel_rise = cyc;
  always @(posedge reg_latch) latch_cnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] x);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = x[7-i];
    return r;
  endfunction

  task automatic send(input logic is_reg, input logic [XW-1:0] w,
                      output logic rej, output int blen);
    @(negedge clk);
    req_valid = 1'b1; req_is_reg = is_reg; req_word = w;
    @(negedge clk);
    req_valid = 1'b0;
    rej = reject;
    blen = 0;
    while (busy) begin
      blen++;
      @(negedge clk);
    end
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic          is_reg, exp_rej, rej;
    logic [XW-1:0] w;
    logic [CW-1:0] exp_ctrl;
    int            blen, c0, l0, s0;
    string         tag;

    exp_ctrl = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 sel_n", 32'(xcvr_sel_n), 1);
    check("R1 ser_clk", 32'(ser_clk), 0);
    check("R1 ser_data", 32'(ser_data), 0);
    check("R1 latch", 32'(reg_latch), 0);
    check("R1 busy", 32'(busy), 0);
    check("R1 ctrl_state", 32'(ctrl_state), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after release", 32'(busy), 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      is_reg  = VEC[i][19];
      exp_rej = VEC[i][18];
      w       = VEC[i][17:0];
      c0 = mon_cnt; l0 = latch_cnt; s0 = sel_low_rises;
      tag = (w[3] && w[4]) ? "R7" : "R8";
      send(is_reg, w, rej, blen);
      check({tag, " reject flag"}, 32'(rej), 32'(exp_rej));
      if (exp_rej) begin
        check({tag, " no busy"}, 32'(blen), 0);
        check({tag, " no bits"}, 32'(mon_cnt - c0), 0);
        check({tag, " no latch"}, 32'(latch_cnt - l0), 0);
        check({tag, " state kept"}, 32'(ctrl_state), 32'(exp_ctrl));
        check("R12 idle sclk", 32'(ser_clk), 0);
        @(negedge clk);
        check({tag, " pulse width"}, 32'(reject), 0);
      end else if (is_reg) begin
        check("R4 busy length", 32'(blen), REG_BUSY);
        check("R4 bit count", 32'(mon_cnt - c0), 8);
        check("R4 sel high", 32'(sel_low_rises - s0), 0);
        check("R4 one latch", 32'(latch_cnt - l0), 1);
        check("R4 bit order", 32'(rev8(mon_shift[7:0])), 32'(w[7:0]));
        check("R6 committed", 32'(ctrl_state), 32'(w[7:0]));
        exp_ctrl = w[7:0];
      end else begin
        check("R3 busy length", 32'(blen), XCVR_BUSY);
        check("R2 bit count", 32'(mon_cnt - c0), XW);
        check("R2 word", 32'(mon_shift[XW-1:0]), 32'(w));
        check("R2 sel low", 32'(sel_low_rises - s0), XW);
        check("R3 lead", 32'(t_first_rise - t_sel_fall), 2 * H);
        check("R3 trail", 32'(t_sel_rise - t_last_fall), 2 * H);
        check("R5 no latch", 32'(latch_cnt - l0), 0);
        check("R5 overlap", 32'(latch_in_sel), 0);
        check("R2 state kept", 32'(ctrl_state), 32'(exp_ctrl));
      end
    end

    // R6: transmit-ready value fields
    send(1'b1, 18'h00013, rej, blen);
    check("R6 power", 32'(ctrl_state[0]), 1);
    check("R6 tx", 32'(ctrl_state[1]), 1);
    check("R6 2G amp", 32'(ctrl_state[4]), 1);
    exp_ctrl = 8'h13;

    // R9: request during busy is ignored
    c0 = mon_cnt; l0 = latch_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_is_reg = 1'b0; req_word = 18'h15555;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (6) @(negedge clk);
    req_valid = 1'b1; req_is_reg = 1'b1; req_word = 18'h000E1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 no reject", 32'(reject), 0);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R9 bits", 32'(mon_cnt - c0), XW);
    check("R9 word", 32'(mon_shift[XW-1:0]), 32'h15555);
    check("R9 no latch", 32'(latch_cnt - l0), 0);
    check("R9 state", 32'(ctrl_state), 32'(exp_ctrl));
    check("R9 idle", 32'(busy), 0);

    // R10: antenna selects
    ant_din = 3'b101;
    @(negedge clk);
    check("R10 hold", 32'(ant_sel), 0);
    ant_wr = 1'b1;
    @(negedge clk);
    ant_wr = 1'b0;
    check("R10 load", 32'(ant_sel), 32'h5);
    ant_din = 3'b010;
    repeat (2) @(negedge clk);
    check("R10 hold after", 32'(ant_sel), 32'h5);

    // R11: lock synchronizer
    lock_raw = 1'b1;
    @(negedge clk);
    check("R11 stage1", 32'(lock_ok), 0);
    @(negedge clk);
    check("R11 stage2", 32'(lock_ok), 1);
    lock_raw = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 drop", 32'(lock_ok), 0);

    // R1: reset mid-transfer
    @(negedge clk);
    req_valid = 1'b1; req_is_reg = 1'b1; req_word = 18'h000E5;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 mid busy", 32'(busy), 0);
    check("R1 mid sclk", 32'(ser_clk), 0);
    check("R1 mid sel", 32'(xcvr_sel_n), 1);
    check("R1 mid state", 32'(ctrl_state), 0);
    check("R1 mid ant", 32'(ant_sel), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule